// File: doc/BRIEF.md
# Bus Target Window Decoder

This block sits at the target side of a 32-bit bus interface. It takes an address phase (address, bus command, byte enables) and checks it against two base address windows. Window 0 covers 256 KB of non-prefetchable local memory. Window 1 covers 1 GB of prefetchable memory. When a memory command hits a window, the block claims the transaction by pulsing device-select. It replaces the upper address bits with the translation value of that window. It then hands a read or write request to an internal request queue.

The two translation values are written through a small write port. Until both have been written since reset, no access can hit. An access with no byte enables is still completed:
- A read fetches a full word.
- A write is claimed and its data is dropped, so no request is queued.

Address phases enter through a valid/ready handshake. Requests leave through another valid/ready handshake. While a request is waiting and `req_ready` is low, `ph_ready` is low and the request fields stay frozen. The block takes a new address phase when no request is pending or when the pending request is consumed in the same cycle.

Top module: `tgt_window_decode`

## Requirements
- R1: Only memory commands can hit. The read commands are 4'h6, 4'hC and 4'hE. The write commands are 4'h7 and 4'hF. Any other command leaves `devsel` low and queues no request.
- R2: Window 0 hits when `ph_addr[31:18]` equals `base0[31:18]`. Window 1 hits when `ph_addr[31:30]` equals `base1[31:30]`. When both windows match, window 0 wins.
- R3: On a window 0 hit, `req_addr` is {translation0[31:18], ph_addr[17:0]}. On a window 1 hit, `req_addr` is {translation1[31:30], ph_addr[29:0]}.
- R4: A cycle with `xlat_we[i]` high loads `xlat_wdata` into translation register i. Only address phases accepted after both registers have been loaded since reset can hit.
- R5: `devsel` is high for exactly the one cycle after an accepted address phase that hits. It stays low after a miss.
- R6: `req_win` is 0 for a window 0 request (non-prefetchable) and 1 for a window 1 request (prefetchable).
- R7: A read request has `req_write`=0 and `req_be`=4'hF, whatever byte enables came with the phase, including none.
- R8: A write that hits with nonzero byte enables queues a request with `req_write`=1 and `req_be` equal to the phase byte enables. A write that hits with byte enables 4'h0 pulses `devsel` and queues no request.
- R9: While `req_valid` is high and `req_ready` is low:
  - `ph_ready` is low;
  - no phase is accepted;
  - the request fields hold their values.

  Otherwise `ph_ready` is high.
- R10: After reset, `devsel` and `req_valid` are low and both translation registers count as unwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_we | input | 2 | Per-window translation register write strobe |
| xlat_wdata | input | 32 | Translation register write data |
| base0 | input | 32 | Window 0 base address |
| base1 | input | 32 | Window 1 base address |
| ph_valid | input | 1 | Address phase present |
| ph_ready | output | 1 | Address phase can be accepted |
| ph_addr | input | 32 | Bus address |
| ph_cmd | input | 4 | Bus command |
| ph_be | input | 4 | Byte enables, active high |
| devsel | output | 1 | Transaction claimed (one-cycle pulse) |
| req_valid | output | 1 | Request to internal queue valid |
| req_ready | input | 1 | Internal queue accepts request |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_win | output | 1 | Window hit: 0 non-prefetchable, 1 prefetchable |
| req_addr | output | 32 | Translated local address |
| req_be | output | 4 | Meaningful byte lanes of the request |

## Verification
If an armed flag is wrong, `devsel` and `req_valid` show it on the cycle after the first accepted phase: a falsely set flag claims a matching access too early, and a stuck-clear flag never claims one. A wrong window compare or substitution width shows up on the next hit as a wrong `req_addr` or `req_win`, and random addresses near both window edges trigger such hits. If the held request register breaks under back-pressure, its fields change while `req_ready` is low. A lost discard decision shows up as a queued zero-enable write.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  localparam int ADDR_W = 32;
  localparam int CMD_W  = 4;
  localparam int BE_W   = 4;
  localparam int NWIN   = 2;

  typedef enum logic {
    WIN_NONPREF = 1'b0,
    WIN_PREF    = 1'b1
  } win_e;

  // Memory command codes accepted by the target
  localparam logic [CMD_W-1:0] CMD_MRD  = 4'h6;
  localparam logic [CMD_W-1:0] CMD_MWR  = 4'h7;
  localparam logic [CMD_W-1:0] CMD_MRDM = 4'hC;
  localparam logic [CMD_W-1:0] CMD_MRDL = 4'hE;
  localparam logic [CMD_W-1:0] CMD_MWRI = 4'hF;
endpackage

// File: rtl/tgt_cmd_decode.sv
module tgt_cmd_decode
  import tgt_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output logic             is_rd,
  output logic             is_wr
);
  always_comb begin
    is_rd = (cmd == CMD_MRD) || (cmd == CMD_MRDM) || (cmd == CMD_MRDL);
    is_wr = (cmd == CMD_MWR) || (cmd == CMD_MWRI);
  end
endmodule

// File: rtl/tgt_xlat_regs.sv
module tgt_xlat_regs
  import tgt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = NWIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] we,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] xlat [NW],
  output logic          armed
);
  logic [NW-1:0] written;

  for (genvar g = 0; g < NW; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        xlat[g]    <= '0;
        written[g] <= 1'b0;
      end else if (we[g]) begin
        xlat[g]    <= wdata;
        written[g] <= 1'b1;
      end
    end
  end

  assign armed = &written;
endmodule

// File: rtl/tgt_win_match.sv
module tgt_win_match
  import tgt_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int OFF_W   = 18
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] xlat,
  output logic          match,
  output logic [AW-1:0] xaddr
);
  localparam int HI_W = AW - OFF_W;

  assign match = (addr[AW-1:OFF_W] == base[AW-1:OFF_W]);
  assign xaddr = {xlat[AW-1:OFF_W], addr[OFF_W-1:0]};

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/tgt_window_decode.sv
module tgt_window_decode
  import tgt_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int W0_OFF = 18,
  parameter int W1_OFF = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NWIN-1:0]    xlat_we,
  input  logic [AW-1:0]      xlat_wdata,
  input  logic [AW-1:0]      base0,
  input  logic [AW-1:0]      base1,
  input  logic               ph_valid,
  output logic               ph_ready,
  input  logic [AW-1:0]      ph_addr,
  input  logic [CMD_W-1:0]   ph_cmd,
  input  logic [BE_W-1:0]    ph_be,
  output logic               devsel,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_write,
  output logic               req_win,
  output logic [AW-1:0]      req_addr,
  output logic [BE_W-1:0]    req_be
);
  logic [AW-1:0]   xlat [NWIN];
  logic            armed;
  logic            is_rd, is_wr;
  logic [NWIN-1:0] match;
  logic [AW-1:0]   xaddr [NWIN];
  logic [AW-1:0]   base_a [NWIN];

  assign base_a[0] = base0;
  assign base_a[1] = base1;

  tgt_xlat_regs #(.AW(AW), .NW(NWIN)) u_xlat (
    .clk(clk), .rst_n(rst_n), .we(xlat_we), .wdata(xlat_wdata),
    .xlat(xlat), .armed(armed)
  );

  tgt_cmd_decode u_cmd (.cmd(ph_cmd), .is_rd(is_rd), .is_wr(is_wr));

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int OFF = (g == 0) ? W0_OFF : W1_OFF;
    tgt_win_match #(.AW(AW), .OFF_W(OFF)) u_match (
      .addr(ph_addr), .base(base_a[g]), .xlat(xlat[g]),
      .match(match[g]), .xaddr(xaddr[g])
    );
  end

  // Combinational decode of the current address phase
  logic         fire, hit, win1, discard;
  logic [AW-1:0] sel_addr;

  assign ph_ready = !req_valid || req_ready;
  assign fire     = ph_valid && ph_ready;

  always_comb begin
    hit      = armed && (is_rd || is_wr) && (match != '0);
    win1     = !match[0];
    sel_addr = win1 ? xaddr[1] : xaddr[0];
    discard  = is_wr && (ph_be == '0);
  end

  // Registered result: medium decode timing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      devsel    <= 1'b0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_win   <= WIN_NONPREF;
      req_addr  <= '0;
      req_be    <= '0;
    end else begin
      devsel <= fire && hit;
      if (fire) begin
        req_valid <= hit && !discard;
        if (hit) begin
          req_write <= is_wr;
          req_win   <= win1 ? WIN_PREF : WIN_NONPREF;
          req_addr  <= sel_addr;
          req_be    <= is_wr ? ph_be : {BE_W{1'b1}};
        end
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tgt_win_chk.sv
module tgt_win_chk
  import tgt_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NWIN-1:0]  xlat_we,
  input logic             ph_valid,
  input logic             ph_ready,
  input logic             devsel,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [BE_W-1:0]  req_be
);
  logic [NWIN-1:0] seen;
  logic            past_ok;
  logic            acc_q, armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0; past_ok <= 1'b0; acc_q <= 1'b0; armed_q <= 1'b0;
    end else begin
      seen    <= seen | xlat_we;
      past_ok <= 1'b1;
      acc_q   <= ph_valid && ph_ready;
      armed_q <= &seen;
    end
  end

  p_devsel_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    devsel |-> (past_ok && acc_q));
  p_armed_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    devsel |-> armed_q);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_be) && $stable(req_write)));
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ph_ready);
  p_read_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> (req_be == {BE_W{1'b1}}));
  p_write_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_be != '0));
endmodule

bind tgt_window_decode tgt_win_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlat_we(xlat_we), .ph_valid(ph_valid),
  .ph_ready(ph_ready), .devsel(devsel), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .req_be(req_be)
);

// File: tb/sim_tgt_window_decode.sv
`timescale 1ns/1ps
module sim_tgt_window_decode;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  xlat_we = 0;
  logic [31:0] xlat_wdata = 0, base0 = 0, base1 = 0, ph_addr = 0;
  logic        ph_valid = 0, req_ready = 1;
  logic [3:0]  ph_cmd = 0, ph_be = 0;
  logic        ph_ready, devsel, req_valid, req_write, req_win;
  logic [31:0] req_addr;
  logic [3:0]  req_be;

  int checks = 0, fails = 0;
  logic [31:0] m_x0 = 0, m_x1 = 0;
  bit m_a0 = 0, m_a1 = 0;

  always #2.5 clk = ~clk;

  tgt_window_decode u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_xlat(input int idx, input logic [31:0] v);
    @(negedge clk); xlat_we = 2'b01 << idx; xlat_wdata = v;
    @(negedge clk); xlat_we = 0;
    if (idx == 0) begin m_a0 = 1; m_x0 = v; end else begin m_a1 = 1; m_x1 = v; end
  endtask

  // Expected model from the requirements
  task automatic expect_of(input logic [31:0] a, input logic [3:0] c, input logic [3:0] be,
                           output bit e_ds, output bit e_rv, output bit e_wr, output bit e_win,
                           output logic [31:0] e_ad, output logic [3:0] e_be);
    bit rd, wr, h0, h1;
    rd = (c == 4'h6) || (c == 4'hC) || (c == 4'hE);
    wr = (c == 4'h7) || (c == 4'hF);
    h0 = m_a0 && m_a1 && (rd || wr) && (a[31:18] == base0[31:18]);
    h1 = m_a0 && m_a1 && (rd || wr) && (a[31:30] == base1[31:30]);
    e_ds  = h0 || h1;
    e_rv  = e_ds && !(wr && be == 0);
    e_wr  = wr;
    e_win = !h0;
    e_ad  = h0 ? {m_x0[31:18], a[17:0]} : {m_x1[31:30], a[29:0]};
    e_be  = wr ? be : 4'hF;
  endtask

  task automatic phase(input logic [31:0] a, input logic [3:0] c, input logic [3:0] be);
    bit e_ds, e_rv, e_wr, e_win; logic [31:0] e_ad; logic [3:0] e_be;
    expect_of(a, c, be, e_ds, e_rv, e_wr, e_win, e_ad, e_be);
    @(negedge clk); ph_valid = 1; ph_addr = a; ph_cmd = c; ph_be = be;
    @(negedge clk); ph_valid = 0;
    chk(devsel == e_ds, "R5/R1/R2/R4 devsel", {31'd0, devsel}, {31'd0, e_ds});
    chk(req_valid == e_rv, "R8/R1 req_valid", {31'd0, req_valid}, {31'd0, e_rv});
    if (e_rv) begin
      chk(req_addr == e_ad, "R3 req_addr", req_addr, e_ad);
      chk(req_win == e_win, "R6 req_win", {31'd0, req_win}, {31'd0, e_win});
      chk(req_write == e_wr, "R7/R8 req_write", {31'd0, req_write}, {31'd0, e_wr});
      chk(req_be == e_be, "R7/R8 req_be", {28'd0, req_be}, {28'd0, e_be});
    end
    @(negedge clk);
    chk(devsel == 0, "R5 devsel one cycle", {31'd0, devsel}, 32'd0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    base0 = 32'h8ABC_0000; base1 = 32'h4000_0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(devsel == 0 && req_valid == 0, "R10 reset outputs", {30'd0, devsel, req_valid}, 32'd0);
    rst_n = 1;
    // R4: no hit before any or only one translation write
    phase(32'h8ABC_0010, 4'h6, 4'hF);
    wr_xlat(0, 32'h1234_5678);
    phase(32'h4000_0020, 4'h7, 4'h3);
    wr_xlat(1, 32'hC000_0000);
    // R2/R3 directed hits, window priority
    phase(32'h8ABC_FFFC, 4'h6, 4'hF);
    phase(32'h7FFF_FFF0, 4'hC, 4'h1);
    base1 = 32'h8000_0000;
    phase(32'h8ABC_0004, 4'hE, 4'h2);   // both match: window 0 wins
    phase(32'h8ABB_FFFC, 4'h7, 4'h5);   // window 1 only
    // R7: read with no byte enables
    phase(32'h8ABC_0100, 4'h6, 4'h0);
    // R8: write with no byte enables -> claimed, discarded
    phase(32'h8ABC_0104, 4'hF, 4'h0);
    // R1: non-memory commands
    phase(32'h8ABC_0108, 4'h2, 4'hF);
    phase(32'h8ABC_0108, 4'hA, 4'hF);
    // R9: back-pressure
    req_ready = 0;
    @(negedge clk); ph_valid = 1; ph_addr = 32'h8ABC_0200; ph_cmd = 4'h7; ph_be = 4'h9;
    @(negedge clk); ph_addr = 32'h8ABC_0300; ph_cmd = 4'h6; ph_be = 4'hF;
    chk(req_valid && req_addr == {m_x0[31:18], 18'h0200}, "R9 first request", req_addr, {m_x0[31:18], 18'h0200});
    chk(ph_ready == 0, "R9 ph_ready low", {31'd0, ph_ready}, 32'd0);
    @(negedge clk); @(negedge clk);
    chk(req_addr == {m_x0[31:18], 18'h0200} && req_be == 4'h9 && req_write, "R9 held fields", req_addr, {m_x0[31:18], 18'h0200});
    chk(devsel == 0, "R9 no accept while stalled", {31'd0, devsel}, 32'd0);
    req_ready = 1;
    @(negedge clk); ph_valid = 0;
    chk(req_valid && req_addr == {m_x0[31:18], 18'h0300} && req_be == 4'hF, "R9 accept after release", req_addr, {m_x0[31:18], 18'h0300});
    @(negedge clk);
    // Random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a; logic [3:0] c, be; int k;
      if ((i % 50) == 0) begin
        base0 = $urandom; base1 = $urandom;
        if ($urandom_range(0, 3) == 0) wr_xlat($urandom_range(0, 1), $urandom);
      end
      k = $urandom_range(0, 2);
      a = $urandom;
      if (k == 0) a[31:18] = base0[31:18];
      else if (k == 1) a[31:30] = base1[31:30];
      case ($urandom_range(0, 5))
        0: c = 4'h6; 1: c = 4'h7; 2: c = 4'hC; 3: c = 4'hE; 4: c = 4'hF;
        default: c = 4'($urandom);
      endcase
      be = ($urandom_range(0, 4) == 0) ? 4'h0 : 4'($urandom);
      phase(a, c, be);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule